// File: doc/BRIEF.md
# Stereo Scanline Rectifier

This block warps the right camera stream of a stereo pair so that its rows line up with the left stream. The left stream is the reference and passes through untouched, so the block handles the right stream alone. Right-camera pixels arrive on the camera clock together with start-of-line and start-of-frame markers. They cross into the processing clock through a small asynchronous FIFO with Gray-coded pointers, with no frame store ahead of it. The processing side then writes them into a ring of scanlines.

A controller follows how many complete source lines of the current frame are resident. It begins an output row only once every source line that row may touch has been written. For each output position it presents the row and column on the index port. An external mapping stage answers in the same cycle with a signed fixed-point source coordinate that has four fractional bits. The block fetches the four neighbouring source pixels, blends them bilinearly and emits the result two cycles later. A flag marks pixels whose source position has no counterpart, so a later correlation stage can skip them.

Top module: `stereo_rectify`

## Requirements
- R1: After reset, and until a frame marker and enough source lines have arrived, `idxValid` and `pixValid` stay low.
- R2: Camera-domain pixels reach the processing domain through an asynchronous FIFO with Gray-coded pointers, in order and without loss, as long as the processing clock drains at least one pixel per camera pixel.
- R3: A pixel with `camFrameStart` high is source row 0, column 0. A pixel with `camLineStart` high is column 0 of the current row. After every LINE_W pixels the row is complete and the next row begins.
- R4: Source row r is held in ring slot r mod RING_LINES (default 64). With REACH = RING_LINES/2 - 2 = 30, no row that an output row may still read is overwritten before that output row ends.
- R5: Output row r starts only once source rows 0 through min(r+REACH+1, IMG_H-1) are complete.
- R6: Each output row issues LINE_W consecutive index cycles with columns 0 to LINE_W-1 and a constant row. Rows run 0 to IMG_H-1 once per frame, and a frame marker restarts the sequence at row 0.
- R7: `srcX` and `srcY` are two's-complement values with 4 fractional bits. The floor gives the top-left neighbour (x0, y0). The other neighbours are x0+1 and y0+1, clamped to LINE_W-1 and IMG_H-1.
- R8: With fractions fx and fy (0..15), the output pixel equals ((p00*(16-fx) + p01*fx)*(16-fy) + (p10*(16-fx) + p11*fx)*fy + 128) >> 8.
- R9: `pixOk` is low and `pixData` is 0 when x0 < 0, x0 > LINE_W-1, y0 < 0, y0 > IMG_H-1, or |y0 - output row| > REACH.
- R10: For every cycle with `idxValid` high, `pixValid` is high exactly two processing cycles later, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| camClk | input | 1 | Camera clock |
| camRstN | input | 1 | Active-low reset, camera domain |
| camValid | input | 1 | Camera pixel present |
| camFrameStart | input | 1 | First pixel of a frame |
| camLineStart | input | 1 | First pixel of a line |
| camPixel | input | PIX_W | Right-camera pixel |
| clk | input | 1 | Processing clock |
| rstN | input | 1 | Active-low reset, processing domain |
| srcX | input | INT_W+FRAC | Source column for the current index, signed fixed point |
| srcY | input | INT_W+FRAC | Source row for the current index, signed fixed point |
| idxValid | output | 1 | Output index presented this cycle |
| idxRow | output | clog2(IMG_H) | Output row index |
| idxCol | output | clog2(LINE_W) | Output column index |
| pixValid | output | 1 | Rectified pixel present |
| pixData | output | PIX_W | Rectified pixel value |
| pixOk | output | 1 | Source position was inside the image and window |

## Verification
The camera keeps streaming while output rows are produced. So in many processing cycles a new pixel is written into the ring, sometimes completing a source line, in the same cycle as the controller tests readiness and reads four neighbours from older lines. A continuous camera stream at a rate unrelated to the processing clock provokes this in every frame. At each row start the bench checks that enough camera pixels had already been sent for the row's whole window. It also recomputes every blended pixel from the known frame pattern, so a premature start or a clobbered slot shows up as a value mismatch.

// File: rtl/rect_pkg.sv
package rect_pkg;
  // strobes handed from control to datapath each cycle
  typedef struct packed {
    logic wrEn;   // write the popped camera pixel into the ring
    logic rdEn;   // an output index is issued this cycle
  } rectStrobe_t;
endpackage

// File: rtl/rect_sync_fifo.sv
module rect_sync_fifo #(
  parameter int DW = 10,
  parameter int AW = 3
) (
  input  logic          wClk,
  input  logic          wRstN,
  input  logic          wEn,
  input  logic [DW-1:0] wData,
  input  logic          rClk,
  input  logic          rRstN,
  output logic          rValid,
  output logic [DW-1:0] rData
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];
  logic [AW:0] wBin, wGray, wBinNext, wGrayNext;
  logic [AW:0] rBin, rGray, rBinNext, rGrayNext;
  logic [AW:0] rGrayW1, rGrayW2, wGrayR1, wGrayR2;
  logic full;

  // write side
  assign full      = (wGray == {~rGrayW2[AW:AW-1], rGrayW2[AW-2:0]});
  assign wBinNext  = wBin + {{AW{1'b0}}, (wEn && !full)};
  assign wGrayNext = (wBinNext >> 1) ^ wBinNext;

  always_ff @(posedge wClk or negedge wRstN) begin
    if (!wRstN) begin
      wBin    <= '0;
      wGray   <= '0;
      rGrayW1 <= '0;
      rGrayW2 <= '0;
    end else begin
      wBin    <= wBinNext;
      wGray   <= wGrayNext;
      rGrayW1 <= rGray;
      rGrayW2 <= rGrayW1;
    end
  end

  always_ff @(posedge wClk) begin
    if (wEn && !full) store[wBin[AW-1:0]] <= wData;
  end

  // read side: drained every cycle it holds data
  assign rValid    = (rGray != wGrayR2);
  assign rData     = store[rBin[AW-1:0]];
  assign rBinNext  = rBin + {{AW{1'b0}}, rValid};
  assign rGrayNext = (rBinNext >> 1) ^ rBinNext;

  always_ff @(posedge rClk or negedge rRstN) begin
    if (!rRstN) begin
      rBin    <= '0;
      rGray   <= '0;
      wGrayR1 <= '0;
      wGrayR2 <= '0;
    end else begin
      rBin    <= rBinNext;
      rGray   <= rGrayNext;
      wGrayR1 <= wGray;
      wGrayR2 <= wGrayR1;
    end
  end
endmodule

// File: rtl/rect_ctrl.sv
module rect_ctrl
  import rect_pkg::*;
#(
  parameter int PIX_W      = 8,
  parameter int LINE_W     = 32,
  parameter int IMG_H      = 80,
  parameter int RING_LINES = 64
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          popValid,
  input  logic                          popFrame,
  input  logic                          popLine,
  input  logic [PIX_W-1:0]              popPix,
  output rectStrobe_t                   strobes,
  output logic [$clog2(RING_LINES)-1:0] wrSlot,
  output logic [$clog2(LINE_W)-1:0]     wrCol,
  output logic [PIX_W-1:0]              wrPix,
  output logic                          idxValid,
  output logic [$clog2(IMG_H)-1:0]      idxRow,
  output logic [$clog2(LINE_W)-1:0]     idxCol
);
  localparam int COL_W  = $clog2(LINE_W);
  localparam int ROW_W  = $clog2(IMG_H);
  localparam int SLOT_W = $clog2(RING_LINES);
  localparam int CNT_W  = ROW_W + 1;
  localparam int REACH  = RING_LINES / 2 - 2;

  typedef enum logic [1:0] {RD_WAIT, RD_RUN, RD_DONE} rdState_t;

  // line tracker (write side)
  logic [CNT_W-1:0] linesDone, baseLines;
  logic [COL_W-1:0] colQ, curCol;
  logic             lastCol;

  always_comb begin
    baseLines = popFrame ? '0 : linesDone;
    curCol    = (popFrame || popLine) ? '0 : colQ;
    lastCol   = (int'(curCol) == LINE_W - 1);
    wrSlot    = SLOT_W'(int'(baseLines) % RING_LINES);
    wrCol     = curCol;
    wrPix     = popPix;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linesDone <= '0;
      colQ      <= '0;
    end else if (popValid) begin
      colQ <= lastCol ? '0 : curCol + 1'b1;
      if (lastCol && int'(baseLines) < IMG_H) linesDone <= baseLines + 1'b1;
      else                                    linesDone <= baseLines;
    end
  end

  // output index generator (read side)
  rdState_t         rdState;
  logic [ROW_W-1:0] rowQ;
  logic [COL_W-1:0] rdColQ;
  logic             rowReady;
  int               needLines;

  always_comb begin
    needLines = int'(rowQ) + REACH + 2;
    if (needLines > IMG_H) needLines = IMG_H;
    rowReady  = int'(linesDone) >= needLines;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdState <= RD_WAIT;
      rowQ    <= '0;
      rdColQ  <= '0;
    end else if (popValid && popFrame) begin
      rdState <= RD_WAIT;
      rowQ    <= '0;
      rdColQ  <= '0;
    end else begin
      unique case (rdState)
        RD_WAIT: if (rowReady) rdState <= RD_RUN;
        RD_RUN: begin
          if (int'(rdColQ) == LINE_W - 1) begin
            rdColQ <= '0;
            if (int'(rowQ) == IMG_H - 1) rdState <= RD_DONE;
            else begin
              rowQ    <= rowQ + 1'b1;
              rdState <= RD_WAIT;
            end
          end else begin
            rdColQ <= rdColQ + 1'b1;
          end
        end
        default: rdState <= RD_DONE;
      endcase
    end
  end

  assign idxValid      = (rdState == RD_RUN);
  assign idxRow        = rowQ;
  assign idxCol        = rdColQ;
  assign strobes.wrEn  = popValid;
  assign strobes.rdEn  = idxValid;
endmodule

// File: rtl/rect_datapath.sv
module rect_datapath
  import rect_pkg::*;
#(
  parameter int PIX_W      = 8,
  parameter int LINE_W     = 32,
  parameter int IMG_H      = 80,
  parameter int RING_LINES = 64,
  parameter int FRAC       = 4,
  parameter int INT_W      = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  rectStrobe_t                   strobes,
  input  logic [$clog2(RING_LINES)-1:0] wrSlot,
  input  logic [$clog2(LINE_W)-1:0]     wrCol,
  input  logic [PIX_W-1:0]              wrPix,
  input  logic [$clog2(IMG_H)-1:0]      rdRow,
  input  logic signed [INT_W+FRAC-1:0]  srcX,
  input  logic signed [INT_W+FRAC-1:0]  srcY,
  output logic                          pixValid,
  output logic [PIX_W-1:0]              pixData,
  output logic                          pixOk
);
  localparam int CRD_W  = INT_W + FRAC;
  localparam int WORDS  = RING_LINES * LINE_W;
  localparam int ADDR_W = $clog2(WORDS);
  localparam int REACH  = RING_LINES / 2 - 2;
  localparam int ONE    = 1 << FRAC;
  localparam int HALF   = 1 << (2 * FRAC - 1);
  localparam int TW     = PIX_W + FRAC + 1;
  localparam int SW     = PIX_W + 2 * FRAC + 2;

  logic [PIX_W-1:0] ring [WORDS];

  always_ff @(posedge clk) begin
    if (strobes.wrEn) ring[ADDR_W'(int'(wrSlot) * LINE_W + int'(wrCol))] <= wrPix;
  end

  // coordinate split and window check
  logic signed [INT_W-1:0] x0, y0;
  logic [FRAC-1:0]         fx, fy;
  logic                    inWin;
  logic [ADDR_W-1:0]       tapAddr [4];

  assign x0 = srcX[CRD_W-1:FRAC];
  assign y0 = srcY[CRD_W-1:FRAC];
  assign fx = srcX[FRAC-1:0];
  assign fy = srcY[FRAC-1:0];

  always_comb begin
    int xa, ya, xb, yb, dRow;
    xa    = int'(x0);
    ya    = int'(y0);
    dRow  = ya - int'(rdRow);
    inWin = (xa >= 0) && (xa <= LINE_W - 1) && (ya >= 0) && (ya <= IMG_H - 1) &&
            (dRow <= REACH) && (dRow >= -REACH);
    xb    = (xa < LINE_W - 1) ? xa + 1 : xa;
    yb    = (ya < IMG_H - 1) ? ya + 1 : ya;
    if (!inWin) begin
      xa = 0; ya = 0; xb = 0; yb = 0;
    end
    tapAddr[0] = ADDR_W'((ya % RING_LINES) * LINE_W + xa);
    tapAddr[1] = ADDR_W'((ya % RING_LINES) * LINE_W + xb);
    tapAddr[2] = ADDR_W'((yb % RING_LINES) * LINE_W + xa);
    tapAddr[3] = ADDR_W'((yb % RING_LINES) * LINE_W + xb);
  end

  // stage 1: neighbour fetch
  logic [PIX_W-1:0] tapPix [4];
  logic [FRAC-1:0]  s1Fx, s1Fy;
  logic             s1Valid, s1Ok;

  for (genvar t = 0; t < 4; t++) begin : g_tap
    always_ff @(posedge clk) tapPix[t] <= ring[tapAddr[t]];
  end

  always_ff @(posedge clk) begin
    s1Fx <= fx;
    s1Fy <= fy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Ok    <= 1'b0;
    end else begin
      s1Valid <= strobes.rdEn;
      s1Ok    <= strobes.rdEn && inWin;
    end
  end

  // stage 2: bilinear blend with rounding
  logic [FRAC:0]    wx0, wy0;
  logic [TW-1:0]    topMix, botMix;
  logic [SW-1:0]    acc;
  logic [PIX_W-1:0] blend;

  always_comb begin
    wx0    = (FRAC+1)'(ONE) - {1'b0, s1Fx};
    wy0    = (FRAC+1)'(ONE) - {1'b0, s1Fy};
    topMix = TW'(tapPix[0]) * TW'(wx0) + TW'(tapPix[1]) * TW'(s1Fx);
    botMix = TW'(tapPix[2]) * TW'(wx0) + TW'(tapPix[3]) * TW'(s1Fx);
    acc    = SW'(topMix) * SW'(wy0) + SW'(botMix) * SW'(s1Fy) + SW'(HALF);
    blend  = acc[2*FRAC +: PIX_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixValid <= 1'b0;
      pixOk    <= 1'b0;
      pixData  <= '0;
    end else begin
      pixValid <= s1Valid;
      pixOk    <= s1Ok;
      pixData  <= s1Ok ? blend : '0;
    end
  end
endmodule

// File: rtl/stereo_rectify.sv
module stereo_rectify
  import rect_pkg::*;
#(
  parameter int PIX_W      = 8,
  parameter int LINE_W     = 32,
  parameter int IMG_H      = 80,
  parameter int RING_LINES = 64,
  parameter int FRAC       = 4,
  parameter int INT_W      = 8,
  parameter int FIFO_AW    = 3
) (
  input  logic                             camClk,
  input  logic                             camRstN,
  input  logic                             camValid,
  input  logic                             camFrameStart,
  input  logic                             camLineStart,
  input  logic [PIX_W-1:0]                 camPixel,
  input  logic                             clk,
  input  logic                             rstN,
  input  logic signed [INT_W+FRAC-1:0]     srcX,
  input  logic signed [INT_W+FRAC-1:0]     srcY,
  output logic                             idxValid,
  output logic [$clog2(IMG_H)-1:0]         idxRow,
  output logic [$clog2(LINE_W)-1:0]        idxCol,
  output logic                             pixValid,
  output logic [PIX_W-1:0]                 pixData,
  output logic                             pixOk
);
  localparam int TOK_W = PIX_W + 2;

  logic [TOK_W-1:0] popTok;
  logic             popValid;
  rectStrobe_t      strobes;
  logic [$clog2(RING_LINES)-1:0] wrSlot;
  logic [$clog2(LINE_W)-1:0]     wrCol;
  logic [PIX_W-1:0]              wrPix;

  rect_sync_fifo #(.DW(TOK_W), .AW(FIFO_AW)) u_sync (
    .wClk  (camClk),
    .wRstN (camRstN),
    .wEn   (camValid),
    .wData ({camFrameStart, camLineStart, camPixel}),
    .rClk  (clk),
    .rRstN (rstN),
    .rValid(popValid),
    .rData (popTok)
  );

  rect_ctrl #(.PIX_W(PIX_W), .LINE_W(LINE_W), .IMG_H(IMG_H), .RING_LINES(RING_LINES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .popValid(popValid),
    .popFrame(popTok[TOK_W-1]),
    .popLine (popTok[TOK_W-2]),
    .popPix  (popTok[PIX_W-1:0]),
    .strobes (strobes),
    .wrSlot  (wrSlot),
    .wrCol   (wrCol),
    .wrPix   (wrPix),
    .idxValid(idxValid),
    .idxRow  (idxRow),
    .idxCol  (idxCol)
  );

  rect_datapath #(.PIX_W(PIX_W), .LINE_W(LINE_W), .IMG_H(IMG_H), .RING_LINES(RING_LINES),
                  .FRAC(FRAC), .INT_W(INT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrSlot  (wrSlot),
    .wrCol   (wrCol),
    .wrPix   (wrPix),
    .rdRow   (idxRow),
    .srcX    (srcX),
    .srcY    (srcY),
    .pixValid(pixValid),
    .pixData (pixData),
    .pixOk   (pixOk)
  );
endmodule

// File: rtl/stereo_rectify_chk.sv
module stereo_rectify_chk #(
  parameter int PIX_W = 8,
  parameter int ROW_W = 7,
  parameter int COL_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             idxValid,
  input logic [ROW_W-1:0] idxRow,
  input logic [COL_W-1:0] idxCol,
  input logic             pixValid,
  input logic [PIX_W-1:0] pixData,
  input logic             pixOk
);
  // R1: nothing is issued in the cycle reset is released
  a_r1_quiet_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!idxValid && !pixValid));

  // R10: every index yields a pixel two cycles later
  a_r10_latency: assert property (@(posedge clk) disable iff (!rstN)
    idxValid |=> ##1 pixValid);

  // R10: no pixel without an index two cycles earlier
  a_r10_no_orphan: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> $past(idxValid, 2));

  // R9: an unmatched pixel carries zero
  a_r9_zero_unmatched: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !pixOk) |-> (pixData == '0));

  // R6: columns step by one inside a row, with the row held
  a_r6_col_step: assert property (@(posedge clk) disable iff (!rstN)
    (idxValid && idxCol != '0) |->
      ($past(idxValid) && (idxCol - $past(idxCol)) == COL_W'(1) && idxRow == $past(idxRow)));
endmodule

bind stereo_rectify stereo_rectify_chk #(
  .PIX_W(PIX_W), .ROW_W($clog2(IMG_H)), .COL_W($clog2(LINE_W))
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .idxValid(idxValid),
  .idxRow  (idxRow),
  .idxCol  (idxCol),
  .pixValid(pixValid),
  .pixData (pixData),
  .pixOk   (pixOk)
);

// File: tb/stereo_rectify_bench.sv
`timescale 1ns/1ps
module stereo_rectify_bench;
  localparam int PIX_W  = 8;
  localparam int LINE_W = 32;
  localparam int IMG_H  = 80;
  localparam int RING   = 64;
  localparam int FRAC   = 4;
  localparam int INT_W  = 8;
  localparam int CRD_W  = INT_W + FRAC;
  localparam int REACH  = RING / 2 - 2;
  localparam int MODES  = 12;
  // stimulus table: coordinate offset per frame in 1/16 pixel, and the expected
  // kind of result (1 = every pixel matched, 0 = none matched, 2 = mixed)
  localparam int OFF_X [MODES] = '{0, 8, 0, 5, -20, 15, 0,   0,   3,    0,    640, -7};
  localparam int OFF_Y [MODES] = '{0, 0, 8, 11, 37, 15, 480, 496, -480, -496, 0,   -9};
  localparam int KIND  [MODES] = '{1, 1, 1, 1, 2,  1,  2,   0,   2,    0,    0,   2};

  logic camClk = 0, clk = 0;
  logic camRstN, rstN, camValid, camFrameStart, camLineStart;
  logic [PIX_W-1:0] camPixel;
  logic signed [CRD_W-1:0] srcX, srcY;
  logic idxValid, pixValid, pixOk;
  logic [$clog2(IMG_H)-1:0] idxRow;
  logic [$clog2(LINE_W)-1:0] idxCol;
  logic [PIX_W-1:0] pixData;

  always #3.5 camClk = ~camClk;
  always #2.5 clk = ~clk;   // 200 MHz

  stereo_rectify #(.PIX_W(PIX_W), .LINE_W(LINE_W), .IMG_H(IMG_H), .RING_LINES(RING),
                   .FRAC(FRAC), .INT_W(INT_W), .FIFO_AW(3)) u_stereo_rectify (
    .camClk(camClk), .camRstN(camRstN), .camValid(camValid), .camFrameStart(camFrameStart),
    .camLineStart(camLineStart), .camPixel(camPixel), .clk(clk), .rstN(rstN),
    .srcX(srcX), .srcY(srcY), .idxValid(idxValid), .idxRow(idxRow), .idxCol(idxCol),
    .pixValid(pixValid), .pixData(pixData), .pixOk(pixOk));

  int checks = 0, failures = 0;
  int curFrame = 0, curDx = 0, curDy = 0, camSent = 0;
  int expRow = 0, expCol = 0, rowsSeen = 0, okSeen = 0, badSeen = 0;
  bit monOn = 0, p1v = 0, p2v = 0;
  int p1e = 0, p2e = 0;

  // mapping stage answers in the index cycle
  always_comb begin
    srcX = CRD_W'(int'(idxCol) * 16 + curDx);
    srcY = CRD_W'(int'(idxRow) * 16 + curDy);
  end

  function automatic int pat(int r, int c, int fr);
    return (r * 29 + c * 7 + fr * 53) & 255;
  endfunction

  // expected blended pixel per R7, R8, R9; -1 when unmatched
  function automatic int expPix(int r, int c, int fr, int dx, int dy);
    int sx, sy, x0, y0, fx, fy, x1, y1, top, bot;
    sx = c * 16 + dx;  sy = r * 16 + dy;
    x0 = sx >>> 4;     y0 = sy >>> 4;
    fx = sx & 15;      fy = sy & 15;
    if (x0 < 0 || x0 > LINE_W - 1 || y0 < 0 || y0 > IMG_H - 1 ||
        y0 - r > REACH || r - y0 > REACH) return -1;
    x1 = (x0 < LINE_W - 1) ? x0 + 1 : x0;
    y1 = (y0 < IMG_H - 1) ? y0 + 1 : y0;
    top = pat(y0, x0, fr) * (16 - fx) + pat(y0, x1, fr) * fx;
    bot = pat(y1, x0, fr) * (16 - fx) + pat(y1, x1, fr) * fx;
    return (top * (16 - fy) + bot * fy + 128) >> 8;
  endfunction

  task automatic fail(string req, string what, int act, int exp);
    failures++;
    $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
  endtask

  task automatic sendFrame(int fr);
    for (int r = 0; r < IMG_H; r++) begin
      for (int c = 0; c < LINE_W; c++) begin
        @(negedge camClk);
        camValid      = 1'b1;
        camFrameStart = (r == 0 && c == 0);
        camLineStart  = (c == 0);
        camPixel      = PIX_W'(pat(r, c, fr));
        camSent++;
      end
    end
    @(negedge camClk);
    camValid = 1'b0; camFrameStart = 1'b0; camLineStart = 1'b0;
  endtask

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (monOn) begin
      if (pixValid || p2v) begin
        checks++;
        if (pixValid !== p2v) fail("R10", "pixValid two cycles after index", pixValid, p2v);
        else if (p2e < 0) begin
          if (pixOk !== 1'b0 || pixData !== '0) fail("R9", "unmatched flag/data", {pixOk, pixData}, 0);
          badSeen++;
        end else begin
          // data path through R2 (crossing), R3 (line framing), R4 (ring slots), R7, R8
          if (pixOk !== 1'b1 || int'(pixData) != p2e) fail("R8", "blended pixel", int'(pixData), p2e);
          okSeen++;
        end
      end
      p2v = p1v; p2e = p1e;
      p1v = idxValid;
      if (idxValid) begin
        checks++;
        if (int'(idxRow) != expRow || int'(idxCol) != expCol)
          fail("R6", "index order row*64+col", int'(idxRow) * 64 + int'(idxCol), expRow * 64 + expCol);
        if (idxCol == 0) begin
          int need;
          need = (int'(idxRow) + REACH + 2 < IMG_H) ? int'(idxRow) + REACH + 2 : IMG_H;
          checks++;
          if (camSent < need * LINE_W) fail("R5", "camera pixels before row start", camSent, need * LINE_W);
        end
        p1e = expPix(int'(idxRow), int'(idxCol), curFrame, curDx, curDy);
        if (expCol == LINE_W - 1) begin expCol = 0; expRow++; rowsSeen++; end
        else expCol++;
      end
    end
  end

  initial begin
    #(150000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    camRstN = 0; rstN = 0; camValid = 0; camFrameStart = 0; camLineStart = 0; camPixel = '0;
    repeat (5) @(negedge clk);
    rstN = 1; camRstN = 1;
    monOn = 1;
    repeat (20) @(negedge clk);
    checks++;
    if (idxValid !== 1'b0 || pixValid !== 1'b0) fail("R1", "idle after reset", {idxValid, pixValid}, 0);

    // table walk: one frame per entry
    for (int m = 0; m < MODES; m++) begin
      curFrame = m; curDx = OFF_X[m]; curDy = OFF_Y[m];
      expRow = 0; expCol = 0; rowsSeen = 0; okSeen = 0; badSeen = 0; camSent = 0;
      sendFrame(m);
      repeat (1500) @(negedge clk);
      checks++;
      if (rowsSeen != IMG_H) fail("R6", "rows per frame", rowsSeen, IMG_H);
      checks++;
      case (KIND[m])
        1: if (badSeen != 0)  fail("R9", "unexpected unmatched pixels", badSeen, 0);
        0: if (okSeen != 0)   fail("R9", "unexpected matched pixels", okSeen, 0);
        default: if (okSeen == 0 || badSeen == 0) fail("R9", "mixed frame matched count", okSeen, 1);
      endcase
    end

    // after the last frame, no further indices appear without a new frame marker
    repeat (200) @(negedge clk);
    checks++;
    if (idxValid !== 1'b0) fail("R6", "idle after final row", idxValid, 0);
    checks++;
    if (rowsSeen != IMG_H) fail("R1", "no extra rows", rowsSeen, IMG_H);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule